// File: doc/BRIEF.md
# Punctured Rate Search Sync Monitor

This block sits beside a punctured convolutional decoder and decides whether the decoder is aligned with the incoming code. A strobe marks each decoded bit, and with it comes an error bit. The error bit comes from re-encoding the decoded output and comparing it with the hard-decision channel bits. The block counts error strobes over a programmable window of valid bits. At the end of each window it compares the count with a programmable limit. A window below the limit declares lock and holds the current rate and puncture phase. A window at or above the limit drops lock and steps the search to the next candidate.

With a fixed code rate selected, only the puncture phase of that rate is scanned. With automatic selection, the scan also walks the rates from 1/2 to 7/8 and wraps back to 1/2. The block reports the rate and phase it is currently trying. Beside the search runs a 16-bit saturating bit-error counter over a programmable period. Its total is latched at the end of every period. A valid flag marks a latched total as trustworthy only when the whole period was spent in lock.

Top module: `punc_sync_search`

## Requirements
- R1: The error limit is `thr_code` × 32. A window passes only when its error count is strictly below the limit, so exactly 32 errors against a limit of 32 fails.
- R2: A window lasts `win_code` × 512 valid strobes. A `win_code` of 0 acts as 1, giving 512. Only cycles with `bit_vld` high advance the window or count errors.
- R3: At the end of a passing window `in_sync` goes high and `cur_rate`/`cur_phase` hold. At the end of a failing window `in_sync` goes low.
- R4: Rate codes are 1=1/2, 2=2/3, 3=3/4, 4=4/5, 5=5/6, 6=6/7 and 7=7/8. Code 0 on `rate_sel` requests automatic search. A rate with code c has c+1 phases, numbered 0 to c on `cur_phase`. `cur_rate` never shows 0.
- R5: With a fixed rate selected, `cur_rate` equals `rate_sel`. A failing window moves `cur_phase` up by one. After the phase equal to the rate code it returns to 0.
- R6: In automatic mode the search starts at rate 1, phase 0. After the last phase of a rate, a failing window moves to phase 0 of the next rate code, and rate 7 is followed by rate 1.
- R7: Any change of `rate_sel` restarts the search on the next clock edge. The window is cleared, `in_sync` drops, `cur_phase` becomes 0 and `cur_rate` becomes the new fixed rate, or 1 in automatic mode.
- R8: The BER period is 64 valid strobes for `ber_sel`=0 and 2^(12+n) valid strobes for `ber_sel`=n≥1. `ber_count` takes the number of error strobes of a period on its last strobe.
- R9: The BER accumulator stops at 0xFFFF and does not wrap.
- R10: `ber_valid` rises only at the end of a BER period spent entirely in lock. It falls in the same cycle that `in_sync` falls.
- R11: After reset `in_sync`, `ber_valid`, `ber_count` and `cur_phase` are 0 and `cur_rate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | One decoded bit is present this cycle |
| bit_err | input | 1 | Re-encoded bit differs from the channel bit |
| rate_sel | input | 3 | Fixed rate code 1..7, or 0 for automatic search |
| thr_code | input | 5 | Error limit in units of 32 |
| win_code | input | 4 | Window length in units of 512 valid strobes |
| ber_sel | input | 3 | BER period select |
| in_sync | output | 1 | Last window passed the limit |
| cur_rate | output | 3 | Rate code under test |
| cur_phase | output | 3 | Puncture phase under test |
| ber_count | output | 16 | Error total of the last completed BER period |
| ber_valid | output | 1 | Latched BER total was gathered fully in lock |

## Verification
The hardest states to reach are deep in the scan: the last phase of 7/8 and the wrap back to 1/2, which come only after dozens of failing windows. The bench acts as the decoder. It raises `bit_err` on every bit unless the reported rate and phase equal a chosen target, so the search runs without help to any position. The limit boundary also needs an exact error total per window. It comes from an error on every sixteenth strobe, which puts exactly 32 errors into any 512-strobe window whatever its alignment.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int RATE_W = 3;
    typedef logic [RATE_W-1:0] rate_t;

    localparam rate_t RATE_AUTO = 3'd0;
    localparam rate_t RATE_MIN  = 3'd1;
    localparam rate_t RATE_MAX  = 3'd7;

    // A rate k/(k+1) sends k+1 channel bits per puncture period, so the
    // highest phase index equals the rate code itself.
    function automatic rate_t last_phase(rate_t r);
        return r;
    endfunction
endpackage

// File: rtl/pss_err_window.sv
module pss_err_window #(
    parameter int THR_W  = 5,
    parameter int THR_SH = 5,
    parameter int WIN_W  = 4,
    parameter int WIN_SH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bit_vld,
    input  logic             bit_err,
    input  logic [THR_W-1:0] thr_code,
    input  logic [WIN_W-1:0] win_code,
    output logic             win_end,
    output logic             win_pass
);
    localparam int LEN_W = WIN_W + WIN_SH;
    localparam int LIM_W = THR_W + THR_SH;
    localparam int CMP_W = (LEN_W > LIM_W) ? LEN_W : LIM_W;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] errs;
    } win_st_t;

    win_st_t st_q, st_d;

    logic [WIN_W-1:0] eff_code;
    logic [LEN_W-1:0] win_len;
    logic [LIM_W-1:0] limit;
    logic [LEN_W-1:0] err_sum;
    logic             last_bit;

    always_comb begin
        eff_code = (win_code == '0) ? WIN_W'(1) : win_code;
        win_len  = {eff_code, {WIN_SH{1'b0}}};
        limit    = {thr_code, {THR_SH{1'b0}}};
        err_sum  = st_q.errs + LEN_W'(bit_vld & bit_err);
        last_bit = bit_vld && (st_q.cnt == win_len - LEN_W'(1));
        win_end  = last_bit && !restart;
        win_pass = CMP_W'(err_sum) < CMP_W'(limit);

        st_d = st_q;
        if (restart || last_bit) begin
            st_d.cnt  = '0;
            st_d.errs = '0;
        end else if (bit_vld) begin
            st_d.cnt  = st_q.cnt + LEN_W'(1);
            st_d.errs = err_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pss_search_fsm.sv
module pss_search_fsm
    import pss_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  rate_t rate_sel,
    input  logic  win_end,
    input  logic  win_pass,
    output logic  restart,
    output logic  in_sync,
    output rate_t cur_rate,
    output rate_t cur_phase
);
    typedef struct packed {
        rate_t sel;
        rate_t rate;
        rate_t phase;
        logic  sync;
    } srch_st_t;

    srch_st_t st_q, st_d;

    always_comb begin
        restart = (rate_sel != st_q.sel);
        st_d     = st_q;
        st_d.sel = rate_sel;
        if (restart) begin
            st_d.rate  = (rate_sel == RATE_AUTO) ? RATE_MIN : rate_sel;
            st_d.phase = '0;
            st_d.sync  = 1'b0;
        end else if (win_end) begin
            if (win_pass) begin
                st_d.sync = 1'b1;
            end else begin
                st_d.sync = 1'b0;
                if (st_q.phase == last_phase(st_q.rate)) begin
                    st_d.phase = '0;
                    if (st_q.sel == RATE_AUTO) begin
                        st_d.rate = (st_q.rate == RATE_MAX) ? RATE_MIN
                                                             : st_q.rate + rate_t'(1);
                    end
                end else begin
                    st_d.phase = st_q.phase + rate_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= RATE_AUTO;
            st_q.rate  <= RATE_MIN;
            st_q.phase <= '0;
            st_q.sync  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_sync   = st_q.sync;
    assign cur_rate  = st_q.rate;
    assign cur_phase = st_q.phase;
endmodule

// File: rtl/pss_ber_meter.sv
module pss_ber_meter #(
    parameter int SEL_W    = 3,
    parameter int CNT_W    = 16,
    parameter int BASE_EXP = 12,
    parameter int MIN_EXP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_err,
    input  logic [SEL_W-1:0] ber_sel,
    input  logic             in_sync,
    input  logic             sync_kill,
    output logic [CNT_W-1:0] ber_count,
    output logic             ber_valid
);
    localparam int PER_W = BASE_EXP + (1 << SEL_W);

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] held;
        logic             clean;
        logic             valid;
    } ber_st_t;

    ber_st_t st_q, st_d;

    logic [PER_W-1:0] per_len;
    logic             per_end;
    logic             sat;
    logic [CNT_W-1:0] acc_nxt;
    logic             locked_now;

    always_comb begin
        if (ber_sel == '0) begin
            per_len = PER_W'(1) << MIN_EXP;
        end else begin
            per_len = PER_W'(1) << (BASE_EXP + int'(ber_sel));
        end
        per_end    = bit_vld && (st_q.per == per_len - PER_W'(1));
        sat        = (st_q.acc == {CNT_W{1'b1}});
        acc_nxt    = st_q.acc + CNT_W'(bit_vld && bit_err && !sat);
        locked_now = in_sync && !sync_kill;

        st_d = st_q;
        if (per_end) begin
            st_d.per   = '0;
            st_d.acc   = '0;
            st_d.held  = acc_nxt;
            st_d.valid = st_q.clean && locked_now;
            st_d.clean = locked_now;
        end else begin
            st_d.per   = st_q.per + PER_W'(bit_vld);
            st_d.acc   = acc_nxt;
            st_d.valid = st_q.valid && locked_now;
            st_d.clean = st_q.clean && locked_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ber_count = st_q.held;
    assign ber_valid = st_q.valid;
endmodule

// File: rtl/punc_sync_search.sv
module punc_sync_search
    import pss_pkg::*;
#(
    parameter int THR_W    = 5,
    parameter int THR_SH   = 5,
    parameter int WIN_W    = 4,
    parameter int WIN_SH   = 9,
    parameter int BSEL_W   = 3,
    parameter int BCNT_W   = 16,
    parameter int BBASE    = 12,
    parameter int BMIN_EXP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_err,
    input  logic [2:0]        rate_sel,
    input  logic [THR_W-1:0]  thr_code,
    input  logic [WIN_W-1:0]  win_code,
    input  logic [BSEL_W-1:0] ber_sel,
    output logic              in_sync,
    output logic [2:0]        cur_rate,
    output logic [2:0]        cur_phase,
    output logic [BCNT_W-1:0] ber_count,
    output logic              ber_valid
);
    logic restart;
    logic win_end;
    logic win_pass;
    logic sync_kill;

    assign sync_kill = restart || (win_end && !win_pass);

    pss_err_window #(
        .THR_W (THR_W),
        .THR_SH(THR_SH),
        .WIN_W (WIN_W),
        .WIN_SH(WIN_SH)
    ) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .bit_vld (bit_vld),
        .bit_err (bit_err),
        .thr_code(thr_code),
        .win_code(win_code),
        .win_end (win_end),
        .win_pass(win_pass)
    );

    pss_search_fsm srch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .win_end  (win_end),
        .win_pass (win_pass),
        .restart  (restart),
        .in_sync  (in_sync),
        .cur_rate (cur_rate),
        .cur_phase(cur_phase)
    );

    pss_ber_meter #(
        .SEL_W   (BSEL_W),
        .CNT_W   (BCNT_W),
        .BASE_EXP(BBASE),
        .MIN_EXP (BMIN_EXP)
    ) ber_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_err  (bit_err),
        .ber_sel  (ber_sel),
        .in_sync  (in_sync),
        .sync_kill(sync_kill),
        .ber_count(ber_count),
        .ber_valid(ber_valid)
    );
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       in_sync,
    input logic [2:0] cur_rate,
    input logic [2:0] cur_phase,
    input logic       ber_valid
);
    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rate != 3'd0) && (cur_phase <= cur_rate));

    assert_fixed_rate_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 3'd0 && $stable(rate_sel) && $past(rst_n)) |-> (cur_rate == rate_sel));

    assert_phase_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cur_phase != $past(cur_phase))
            |-> (cur_phase == $past(cur_phase) + 3'd1 || cur_phase == 3'd0));

    assert_lock_holds_position_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && $past(in_sync)) |-> ($stable(cur_phase) && $stable(cur_rate)));

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rate_sel != $past(rate_sel)) |=> (!in_sync && cur_phase == 3'd0));

    assert_valid_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ber_valid |-> in_sync);

    assert_valid_rise_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ber_valid) |-> $past(in_sync));
endmodule

bind punc_sync_search pss_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .in_sync  (in_sync),
    .cur_rate (cur_rate),
    .cur_phase(cur_phase),
    .ber_valid(ber_valid)
);

// File: tb/punc_sync_search_tb_top.sv
module punc_sync_search_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b1;
    logic        bit_err;
    logic [2:0]  rate_sel = 3'd0;
    logic [4:0]  thr_code = 5'd1;
    logic [3:0]  win_code = 4'd1;
    logic [2:0]  ber_sel = 3'd0;
    logic        in_sync;
    logic [2:0]  cur_rate;
    logic [2:0]  cur_phase;
    logic [15:0] ber_count;
    logic        ber_valid;

    // decoder model: 0 = errors unless at target, 1 = every 16th bit, 2 = every bit
    logic [1:0]  emode = 2'd0;
    logic [2:0]  tgt_rate = 3'd0;
    logic [2:0]  tgt_phase = 3'd0;
    logic [31:0] vcnt = 0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) vcnt <= vcnt + 1;

    always_comb begin
        if (emode == 2'd2)      bit_err = 1'b1;
        else if (emode == 2'd1) bit_err = (vcnt[3:0] == 4'd0);
        else                    bit_err = !(cur_rate == tgt_rate && cur_phase == tgt_phase);
    end

    punc_sync_search dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_err  (bit_err),
        .rate_sel (rate_sel),
        .thr_code (thr_code),
        .win_code (win_code),
        .ber_sel  (ber_sel),
        .in_sync  (in_sync),
        .cur_rate (cur_rate),
        .cur_phase(cur_phase),
        .ber_count(ber_count),
        .ber_valid(ber_valid)
    );

    // {rate_sel, target rate, target phase, failing windows before lock}
    localparam logic [16:0] VEC [0:6] = '{
        {3'd0, 3'd1, 3'd0, 8'd0},
        {3'd0, 3'd3, 3'd2, 8'd7},
        {3'd0, 3'd7, 3'd7, 8'd34},
        {3'd3, 3'd3, 3'd3, 8'd3},
        {3'd1, 3'd1, 3'd1, 8'd1},
        {3'd7, 3'd7, 3'd5, 8'd5},
        {3'd5, 3'd5, 3'd4, 8'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        do_reset();
        chk("R11 in_sync", {31'd0, in_sync}, 0);
        chk("R11 ber_valid", {31'd0, ber_valid}, 0);
        chk("R11 ber_count", {16'd0, ber_count}, 0);
        chk("R11 cur_rate", {29'd0, cur_rate}, 1);
        chk("R11 cur_phase", {29'd0, cur_phase}, 0);

        // R3 R4 R5 R6: table of searches that end in lock
        for (int i = 0; i < 7; i++) begin
            logic [16:0] v;
            int nfail;
            v = VEC[i];
            rate_sel = v[16:14];
            tgt_rate = v[13:11];
            tgt_phase = v[10:8];
            nfail = int'(v[7:0]);
            emode = 2'd0; thr_code = 5'd1; win_code = 4'd1; ber_sel = 3'd0;
            do_reset();
            wait_n((nfail + 1) * 512 - 8);
            chk("R3 not yet locked", {31'd0, in_sync}, 0);
            wait_n(16);
            chk("R3 locked", {31'd0, in_sync}, 1);
            chk("R4 locked rate", {29'd0, cur_rate}, {29'd0, tgt_rate});
            chk("R5 R6 locked phase", {29'd0, cur_phase}, {29'd0, tgt_phase});
        end

        // R5: fixed rate phase wrap
        rate_sel = 3'd1; tgt_rate = 3'd0; emode = 2'd0;
        do_reset();
        wait_n(512 + 8);
        chk("R5 phase step", {29'd0, cur_phase}, 1);
        wait_n(512);
        chk("R5 phase wrap", {29'd0, cur_phase}, 0);
        chk("R5 rate held", {29'd0, cur_rate}, 1);
        chk("R3 no lock on fail", {31'd0, in_sync}, 0);

        // R6: automatic rate walk and wrap
        rate_sel = 3'd0;
        do_reset();
        wait_n(2 * 512 + 8);
        chk("R6 next rate", {29'd0, cur_rate}, 2);
        chk("R6 next rate phase", {29'd0, cur_phase}, 0);
        wait_n(32 * 512);
        chk("R6 last rate", {29'd0, cur_rate}, 7);
        chk("R6 last phase", {29'd0, cur_phase}, 7);
        wait_n(512);
        chk("R6 rate wrap", {29'd0, cur_rate}, 1);
        chk("R6 phase wrap", {29'd0, cur_phase}, 0);

        // R1: exactly 32 errors per window at the limit boundary
        rate_sel = 3'd1; emode = 2'd1; thr_code = 5'd1;
        do_reset();
        wait_n(3 * 512 + 8);
        chk("R1 count equal to limit fails", {31'd0, in_sync}, 0);
        thr_code = 5'd2;
        do_reset();
        wait_n(512 + 8);
        chk("R1 count below limit passes", {31'd0, in_sync}, 1);
        chk("R1 phase kept", {29'd0, cur_phase}, 0);

        // R2: window length
        emode = 2'd0; tgt_rate = 3'd1; tgt_phase = 3'd0; thr_code = 5'd1; win_code = 4'd2;
        do_reset();
        wait_n(1024 - 8);
        chk("R2 window of 1024 not ended", {31'd0, in_sync}, 0);
        wait_n(16);
        chk("R2 window of 1024 ended", {31'd0, in_sync}, 1);
        win_code = 4'd0;
        do_reset();
        wait_n(512 + 8);
        chk("R2 code zero gives 512", {31'd0, in_sync}, 1);

        // R7: rate select change restarts
        rate_sel = 3'd2;
        wait_n(2);
        chk("R7 sync dropped", {31'd0, in_sync}, 0);
        chk("R7 new rate", {29'd0, cur_rate}, 2);
        chk("R7 phase cleared", {29'd0, cur_phase}, 0);

        // R8 R10: BER period 64 with 4 errors, valid only after locked period
        rate_sel = 3'd1; emode = 2'd1; thr_code = 5'd2; win_code = 4'd1; ber_sel = 3'd0;
        do_reset();
        wait_n(300);
        chk("R8 count per 64 strobes", {16'd0, ber_count}, 4);
        chk("R10 not valid before lock", {31'd0, ber_valid}, 0);
        wait_n(512);
        chk("R3 locked with sparse errors", {31'd0, in_sync}, 1);
        chk("R10 valid after locked period", {31'd0, ber_valid}, 1);
        emode = 2'd2;
        wait_n(520);
        chk("R3 sync lost", {31'd0, in_sync}, 0);
        chk("R10 valid dropped", {31'd0, ber_valid}, 0);
        chk("R5 phase moved on loss", {29'd0, cur_phase}, 1);

        // R8: period 2^15
        emode = 2'd2; ber_sel = 3'd3;
        do_reset();
        wait_n(32768 - 10);
        chk("R8 not latched early", {16'd0, ber_count}, 0);
        wait_n(20);
        chk("R8 period 2^15 count", {16'd0, ber_count}, 32'h8000);

        // R9: saturation over a period of 2^16 all-error strobes
        ber_sel = 3'd4;
        do_reset();
        wait_n(65536 + 10);
        chk("R9 saturated count", {16'd0, ber_count}, 32'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule